// File: doc/BRIEF.md
# Keyboard Command Sequencer

This block runs the host side of the short command exchanges a PS/2 keyboard understands. It sits above a byte-level transmitter (a byte and a start strobe go in, a completion strobe comes back) and a byte-level receiver (a byte with a valid strobe). A request on one of five inputs starts a sequence. The block sends the command byte. For the two-byte commands it then waits for the keyboard's acknowledge, bounded by a programmable cycle timeout, and only after that sends the parameter byte. A one-cycle done or error pulse ends every sequence.

The two-byte commands set the lock-indicator LEDs from a 3-bit value and set the typematic repeat rate from an 8-bit value. The echo command expects the keyboard to return the echo code. The resend and reset commands are fire-and-forget: the sequence completes once the byte has gone out. The bit-level open-collector signalling and scan-code decoding belong to other blocks.

Top module: `kbd_cmd_seq`

## Requirements
- R1: After reset, busy_o, done_o, error_o and tx_start_o are 0 and tx_data_o is 0x00.
- R2: An LED request sends 0xED. After 0xFA is received it sends the byte {5'b0, led_val_i}, where bit 0 is Scroll Lock, bit 1 is Num Lock and bit 2 is Caps Lock, and a 1 lights the LED.
- R3: A rate request sends 0xF3. After 0xFA is received it sends rate_val_i unchanged.
- R4: An echo request sends 0xEE, and the sequence completes when 0xEE is received.
- R5: A resend request sends 0xFE and a reset request sends 0xFF. Each completes on tx_done_i for that byte, with no wait for a reply.
- R6: In the reply wait, if no byte arrives within timeout_cycles_i cycles after the tx_done_i of the command byte, error_o pulses and the block returns to idle without sending a parameter byte. A reply that arrives in the last cycle of the window is still accepted.
- R7: In the reply wait, any received byte other than the expected reply pulses error_o and returns the block to idle.
- R8: While busy_o is 1, new requests are ignored and are not queued.
- R9: done_o pulses for exactly one cycle, on the cycle after tx_done_i of the final byte or after the accepted echo reply. done_o and error_o are never high together, and busy_o is 0 in the cycle either of them is high.
- R10: When several requests arrive in the same idle cycle, exactly one is served, in the priority order LED, rate, echo, resend, reset.
- R11: tx_start_o is a one-cycle pulse issued together with a new tx_data_o, and tx_data_o holds its value until the next tx_start_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| led_req_i | input | 1 | Start an LED update |
| led_val_i | input | 3 | LED states: bit 2 Caps, bit 1 Num, bit 0 Scroll |
| rate_req_i | input | 1 | Start a repeat-rate update |
| rate_val_i | input | 8 | Repeat-rate parameter byte |
| echo_req_i | input | 1 | Start an echo exchange |
| resend_req_i | input | 1 | Send the resend command |
| reset_req_i | input | 1 | Send the keyboard reset command |
| timeout_cycles_i | input | TO_W | Reply wait limit, in clock cycles |
| tx_data_o | output | 8 | Byte to transmit |
| tx_start_o | output | 1 | Start transmitting tx_data_o |
| tx_done_i | input | 1 | Transmitter finished the current byte |
| rx_data_i | input | 8 | Byte received from the keyboard |
| rx_valid_i | input | 1 | rx_data_i is valid this cycle |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Sequence completed (one cycle) |
| error_o | output | 1 | Sequence aborted (one cycle) |

## Verification
Each command kind is run to completion with distinct parameter values: LED masks with the outer bits set, and a rate byte with mixed bits. These show that the correct command code and parameter byte appear in the correct order. The reply-wait stage gets the right reply, a wrong reply (including the acknowledge code during an echo), silence, and a reply placed on the last and on the first-too-late cycle of the timeout window. These separate acceptance, rejection and the off-by-one edge of the timer. Simultaneous requests, and requests raised mid-sequence, separate the priority order from the rule that requests are ignored while busy. A stray tx_done_i or received byte while idle confirms that neither starts anything.

// File: rtl/kbd_cmd_pkg.sv
package kbd_cmd_pkg;
  localparam logic [7:0] CMD_LED    = 8'hED;
  localparam logic [7:0] CMD_RATE   = 8'hF3;
  localparam logic [7:0] CMD_ECHO   = 8'hEE;
  localparam logic [7:0] CMD_RESEND = 8'hFE;
  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] RSP_ACK    = 8'hFA;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_ACK, ST_PARAM} seq_state_e;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] param;
    logic [7:0] expect_rsp;
    logic       need_rsp;
    logic       has_param;
  } seq_req_t;
endpackage

// File: rtl/kbd_req_sel.sv
module kbd_req_sel
  import kbd_cmd_pkg::*;
#(
  parameter int LED_W = 3
) (
  input  logic             led_req_i,
  input  logic [LED_W-1:0] led_val_i,
  input  logic             rate_req_i,
  input  logic [7:0]       rate_val_i,
  input  logic             echo_req_i,
  input  logic             resend_req_i,
  input  logic             reset_req_i,
  output logic             valid_o,
  output seq_req_t         req_o
);
  localparam int PAD_W = 8 - LED_W;

  logic [7:0] led_byte;

  generate
    if (PAD_W > 0) begin : g_pad
      assign led_byte = {{PAD_W{1'b0}}, led_val_i};
    end else begin : g_nopad
      assign led_byte = led_val_i[7:0];
    end
  endgenerate

  assign valid_o = led_req_i | rate_req_i | echo_req_i | resend_req_i | reset_req_i;

  // fixed priority: led > rate > echo > resend > reset
  always_comb begin
    req_o = '0;
    if (led_req_i) begin
      req_o = '{cmd: CMD_LED, param: led_byte, expect_rsp: RSP_ACK, need_rsp: 1'b1, has_param: 1'b1};
    end else if (rate_req_i) begin
      req_o = '{cmd: CMD_RATE, param: rate_val_i, expect_rsp: RSP_ACK, need_rsp: 1'b1, has_param: 1'b1};
    end else if (echo_req_i) begin
      req_o = '{cmd: CMD_ECHO, param: 8'h00, expect_rsp: CMD_ECHO, need_rsp: 1'b1, has_param: 1'b0};
    end else if (resend_req_i) begin
      req_o = '{cmd: CMD_RESEND, param: 8'h00, expect_rsp: 8'h00, need_rsp: 1'b0, has_param: 1'b0};
    end else if (reset_req_i) begin
      req_o = '{cmd: CMD_RESET, param: 8'h00, expect_rsp: 8'h00, need_rsp: 1'b0, has_param: 1'b0};
    end
  end
endmodule

// File: rtl/kbd_rsp_timer.sv
module kbd_rsp_timer #(
  parameter int CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt   = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign expired_o = en_i && (cnt_nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
  import kbd_cmd_pkg::*;
#(
  parameter int LED_W = 3,
  parameter int TO_W  = 21
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            led_req_i,
  input  logic [LED_W-1:0] led_val_i,
  input  logic            rate_req_i,
  input  logic [7:0]      rate_val_i,
  input  logic            echo_req_i,
  input  logic            resend_req_i,
  input  logic            reset_req_i,
  input  logic [TO_W-1:0] timeout_cycles_i,
  output logic [7:0]      tx_data_o,
  output logic            tx_start_o,
  input  logic            tx_done_i,
  input  logic [7:0]      rx_data_i,
  input  logic            rx_valid_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            error_o
);
  seq_state_e state_q;
  seq_req_t   cur_q, sel_req;
  logic       sel_valid, to_expired;

  kbd_req_sel #(.LED_W(LED_W)) u_sel (
    .led_req_i   (led_req_i),
    .led_val_i   (led_val_i),
    .rate_req_i  (rate_req_i),
    .rate_val_i  (rate_val_i),
    .echo_req_i  (echo_req_i),
    .resend_req_i(resend_req_i),
    .reset_req_i (reset_req_i),
    .valid_o     (sel_valid),
    .req_o       (sel_req)
  );

  kbd_rsp_timer #(.CNT_W(TO_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_ACK),
    .en_i     ((state_q == ST_ACK) && !rx_valid_i),
    .limit_i  (timeout_cycles_i),
    .expired_o(to_expired)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      tx_data_o  <= 8'h00;
      tx_start_o <= 1'b0;
      done_o     <= 1'b0;
      error_o    <= 1'b0;
    end else begin
      tx_start_o <= 1'b0;
      done_o     <= 1'b0;
      error_o    <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (sel_valid) begin
          cur_q      <= sel_req;
          tx_data_o  <= sel_req.cmd;
          tx_start_o <= 1'b1;
          state_q    <= ST_CMD;
        end
        ST_CMD: if (tx_done_i) begin
          if (cur_q.need_rsp) begin
            state_q <= ST_ACK;
          end else begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_ACK: begin
          if (rx_valid_i) begin
            if (rx_data_i != cur_q.expect_rsp) begin
              error_o <= 1'b1;
              state_q <= ST_IDLE;
            end else if (cur_q.has_param) begin
              tx_data_o  <= cur_q.param;
              tx_start_o <= 1'b1;
              state_q    <= ST_PARAM;
            end else begin
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (to_expired) begin
            error_o <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_PARAM: if (tx_done_i) begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kbd_cmd_seq_chk.sv
module kbd_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] tx_data_o,
  input logic       tx_start_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       error_o
);
  p_start_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  p_start_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> busy_o);

  p_data_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_start_o |-> $stable(tx_data_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_end_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  p_end_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) |-> !busy_o);

  // first byte of a sequence is always a known command code
  p_cmd_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && !$past(busy_o)) |->
      (tx_data_o == 8'hED || tx_data_o == 8'hF3 || tx_data_o == 8'hEE ||
       tx_data_o == 8'hFE || tx_data_o == 8'hFF));
endmodule

bind kbd_cmd_seq kbd_cmd_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_data_o (tx_data_o),
  .tx_start_o(tx_start_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .error_o   (error_o)
);

// File: tb/kbd_cmd_seq_bench.sv
module kbd_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TO_W = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic led_req = 0, rate_req = 0, echo_req = 0, resend_req = 0, reset_req = 0;
  logic [2:0] led_val = 0;
  logic [7:0] rate_val = 0, rx_data = 0;
  logic tx_done = 0, rx_valid = 0;
  logic [TO_W-1:0] timeout = 21'd10;
  logic [7:0] tx_data;
  logic tx_start, busy, done, error;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_cmd_seq u_kbd_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .led_req_i(led_req), .led_val_i(led_val),
    .rate_req_i(rate_req), .rate_val_i(rate_val),
    .echo_req_i(echo_req), .resend_req_i(resend_req), .reset_req_i(reset_req),
    .timeout_cycles_i(timeout),
    .tx_data_o(tx_data), .tx_start_o(tx_start), .tx_done_i(tx_done),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .busy_o(busy), .done_o(done), .error_o(error)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference: phase 0 idle, 1 command out, 2 awaiting reply, 3 parameter out
  int   m_phase = 0, m_wait = 0;
  bit [7:0] m_data = 0, m_cmd = 0, m_param = 0;
  bit   m_start = 0, m_done = 0, m_err = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_wait = 0; m_data = 0; m_cmd = 0; m_param = 0;
      m_start = 0; m_done = 0; m_err = 0;
    end else begin
      m_start = 0; m_done = 0; m_err = 0;
      if (m_phase == 0) begin
        if (led_req || rate_req || echo_req || resend_req || reset_req) begin
          if (led_req)         begin m_cmd = 8'hED; m_param = {5'b0, led_val}; end
          else if (rate_req)   begin m_cmd = 8'hF3; m_param = rate_val; end
          else if (echo_req)   m_cmd = 8'hEE;
          else if (resend_req) m_cmd = 8'hFE;
          else                 m_cmd = 8'hFF;
          m_data = m_cmd; m_start = 1; m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (tx_done) begin
          if (m_cmd == 8'hFE || m_cmd == 8'hFF) begin m_done = 1; m_phase = 0; end
          else begin m_phase = 2; m_wait = 0; end
        end
      end else if (m_phase == 2) begin
        if (rx_valid) begin
          if (rx_data == ((m_cmd == 8'hEE) ? 8'hEE : 8'hFA)) begin
            if (m_cmd == 8'hEE) begin m_done = 1; m_phase = 0; end
            else begin m_data = m_param; m_start = 1; m_phase = 3; end
          end else begin m_err = 1; m_phase = 0; end
        end else begin
          m_wait++;
          if (m_wait >= int'(timeout)) begin m_err = 1; m_phase = 0; end
        end
      end else begin
        if (tx_done) begin m_done = 1; m_phase = 0; end
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    cmp("busy", int'(busy), int'(m_phase != 0));
    cmp("tx_start", int'(tx_start), int'(m_start));
    cmp("tx_data", int'(tx_data), int'(m_data));
    cmp("done", int'(done), int'(m_done));
    cmp("error", int'(error), int'(m_err));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    #1 tx_done = 1; tick(1); #1 tx_done = 0;
  endtask

  task automatic pulse_rx(logic [7:0] b);
    #1 rx_data = b; rx_valid = 1; tick(1); #1 rx_valid = 0;
  endtask

  // raise the given request lines for one cycle
  task automatic req(bit l, bit r, bit e, bit rs, bit rt);
    #1 led_req = l; rate_req = r; echo_req = e; resend_req = rs; reset_req = rt;
    tick(1);
    #1 led_req = 0; rate_req = 0; echo_req = 0; resend_req = 0; reset_req = 0;
  endtask

  task automatic two_byte(bit is_led);
    req(is_led, !is_led, 0, 0, 0); tick(2);
    pulse_done(); tick(2);
    pulse_rx(8'hFA); tick(2);
    pulse_done(); tick(2);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    tick(3);
    #1 rst_n = 1;
    tick(2);

    cur_req = "R2"; led_val = 3'b101; two_byte(1);
    led_val = 3'b010; two_byte(1);
    cur_req = "R3"; rate_val = 8'h2B; two_byte(0);
    rate_val = 8'hD4; two_byte(0);

    cur_req = "R4"; req(0, 0, 1, 0, 0); tick(1); pulse_done(); tick(3); pulse_rx(8'hEE); tick(2);

    cur_req = "R5"; req(0, 0, 0, 1, 0); tick(2); pulse_done(); tick(2);
    req(0, 0, 0, 0, 1); tick(2); pulse_done(); tick(2);

    cur_req = "R6"; led_val = 3'b111; req(1, 0, 0, 0, 0); tick(1); pulse_done(); tick(14);
    // reply in the last cycle of the window is accepted
    req(1, 0, 0, 0, 0); tick(1); pulse_done(); tick(9); pulse_rx(8'hFA); tick(1); pulse_done(); tick(2);
    // reply one cycle too late
    req(1, 0, 0, 0, 0); tick(1); pulse_done(); tick(10); pulse_rx(8'hFA); tick(3);
    timeout = 21'd1; req(0, 1, 0, 0, 0); tick(1); pulse_done(); tick(3);
    timeout = 21'd10;

    cur_req = "R7"; req(0, 1, 0, 0, 0); tick(1); pulse_done(); tick(2); pulse_rx(8'hFE); tick(2);
    req(0, 0, 1, 0, 0); tick(1); pulse_done(); tick(1); pulse_rx(8'hFA); tick(2);

    cur_req = "R8"; led_val = 3'b001; req(1, 0, 0, 0, 0); tick(1);
    req(0, 1, 1, 0, 0); pulse_done(); req(0, 0, 0, 1, 1); pulse_rx(8'hFA);
    req(0, 1, 0, 0, 0); pulse_done(); tick(2);
    // stray strobes while idle start nothing
    pulse_done(); pulse_rx(8'hFA); tick(2);

    cur_req = "R10"; led_val = 3'b100; rate_val = 8'h11;
    req(1, 1, 1, 1, 1); tick(1); pulse_done(); tick(1); pulse_rx(8'hFA); tick(1); pulse_done(); tick(2);
    req(0, 1, 0, 0, 1); tick(1); pulse_done(); tick(1); pulse_rx(8'hFA); tick(1); pulse_done(); tick(2);
    req(0, 0, 1, 1, 0); tick(1); pulse_done(); tick(1); pulse_rx(8'hEE); tick(2);
    req(0, 0, 0, 1, 1); tick(1); pulse_done(); tick(2);

    // R9 and R11 are compared on every cycle of the runs above
    cur_req = "R9"; req(0, 0, 0, 0, 1); pulse_done(); tick(2);
    cur_req = "R11"; rate_val = 8'h5A; two_byte(0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule